// File: doc/BRIEF.md
# Memory-Mapped Clock Crossing Bridge

The bridge links one memory-mapped master, clocked by `m_clk_i`, to one memory-mapped slave, clocked by an unrelated `s_clk_i`. It moves one single read or write at a time. The master is stalled with `m_wait_o` from its first request cycle until the slave side has finished the access. The slave sees an ordinary access that honours its own `s_wait_i`.

Each domain has its own state machine. The two machines exchange only a request and an acknowledge, and each of these passes through a multi-flop synchronizer. The handshake is four-phase. Address, byte enables, write data and the captured operation type are not synchronized. They are sampled directly because the master holds them constant while it is stalled.

Read data is captured in a register in the slave domain and driven to the master from there. The register stays steady from the moment of capture until the next read.

Top module: `mm_cdc_bridge`

## Requirements
- R1: After reset, and with no request pending, `m_wait_o`, `s_read_o` and `s_write_o` are all 0.
- R2: When the master is idle and raises `m_read_i` or `m_write_i`, `m_wait_o` is 1 in that same cycle.
- R3: Each master write causes exactly one slave write that completes. That write carries the master's address, write data and byte enables. `s_read_o` and `s_write_o` are never both 1.
- R4: On a read, `m_rdata_o` equals the `s_rdata_i` value present when the slave completed the access (strobe high with `s_wait_i` 0). The value is valid in the master cycle where `m_wait_o` is 0.
- R5: While `s_wait_i` is 1, the slave strobe and its type stay unchanged. Each master transfer gives exactly one slave completion.
- R6: Only one transfer is in flight. The request stays high until the acknowledge is seen, and the acknowledge stays high until the request falls. A new request starts only when the acknowledge is low. When a master transfer completes, the count of slave completions equals the count of master transfers.
- R7: Transfers behave as in R3 to R5 whether the slave clock is faster than, slower than, or close to the master clock.
- R8: After a read, `m_rdata_o` holds its value through idle cycles and through later writes, until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk_i | input | 1 | Master-domain clock |
| s_clk_i | input | 1 | Slave-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| m_addr_i | input | ADDR_W | Master address, held while stalled |
| m_be_i | input | DATA_W/8 | Master byte enables |
| m_wdata_i | input | DATA_W | Master write data |
| m_read_i | input | 1 | Master read request |
| m_write_i | input | 1 | Master write request (wins if both are set) |
| m_rdata_o | output | DATA_W | Read data, from the slave-domain register |
| m_wait_o | output | 1 | Master stall |
| s_addr_o | output | ADDR_W | Slave address |
| s_be_o | output | DATA_W/8 | Slave byte enables |
| s_wdata_o | output | DATA_W | Slave write data |
| s_read_o | output | 1 | Slave read strobe |
| s_write_o | output | 1 | Slave write strobe |
| s_rdata_i | input | DATA_W | Slave read data |
| s_wait_i | input | 1 | Slave stall |

## Verification
The bench builds the bridge with ADDR_W=16, DATA_W=32 and SYNC_STAGES=2. It runs the bridge in turn with a slave clock of 4 ns, 26 ns and 10 ns against the 8 ns master clock, so both the fast-slave and the slow-slave sides of the handshake are exercised. The slave model adds a random number of wait states to each access. It decodes only the low four address bits, so reads often return data from earlier partial-byte-enable writes. This tests whether payload sampled without synchronization arrives intact.

// File: rtl/mm_cdc_pkg.sv
package mm_cdc_pkg;
  typedef enum logic [1:0] {M_IDLE, M_REQ, M_REL, M_DONE} m_state_e;
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_ACK} s_state_e;
endpackage

// File: rtl/mm_cdc_sync.sv
module mm_cdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/mm_cdc_mfsm.sv
module mm_cdc_mfsm
  import mm_cdc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_i,
  input  logic write_i,
  input  logic ack_i,
  output logic wait_o,
  output logic req_o,
  output logic wr_o
);
  m_state_e state_q;
  logic     req_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        M_IDLE: if ((read_i || write_i) && !ack_i) begin
          req_q   <= 1'b1;
          wr_q    <= write_i;
          state_q <= M_REQ;
        end
        M_REQ: if (ack_i) begin
          req_q   <= 1'b0;
          state_q <= M_REL;
        end
        M_REL:   if (!ack_i) state_q <= M_DONE;
        M_DONE:  state_q <= M_IDLE;
        default: state_q <= M_IDLE;
      endcase
    end
  end

  // stall at once on a new request; release for one cycle after ack falls
  always_comb begin
    unique case (state_q)
      M_IDLE:  wait_o = read_i || write_i;
      M_DONE:  wait_o = 1'b0;
      default: wait_o = 1'b1;
    endcase
  end

  assign req_o = req_q;
  assign wr_o  = wr_q;
endmodule

// File: rtl/mm_cdc_sfsm.sv
module mm_cdc_sfsm
  import mm_cdc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              read_o,
  output logic              write_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o
);
  s_state_e          state_q;
  logic              wr_q, ack_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_i) begin
          wr_q    <= wr_i;  // stable while the request is up
          state_q <= S_XFER;
        end
        S_XFER: if (!wait_i) begin
          if (!wr_q) rdata_q <= rdata_i;
          ack_q   <= 1'b1;
          state_q <= S_ACK;
        end
        S_ACK: if (!req_i) begin
          ack_q   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign read_o  = (state_q == S_XFER) && !wr_q;
  assign write_o = (state_q == S_XFER) &&  wr_q;
  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/mm_cdc_bridge.sv
module mm_cdc_bridge #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              m_clk_i,
  input  logic              s_clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] m_addr_i,
  input  logic [BE_W-1:0]   m_be_i,
  input  logic [DATA_W-1:0] m_wdata_i,
  input  logic              m_read_i,
  input  logic              m_write_i,
  output logic [DATA_W-1:0] m_rdata_o,
  output logic              m_wait_o,
  output logic [ADDR_W-1:0] s_addr_o,
  output logic [BE_W-1:0]   s_be_o,
  output logic [DATA_W-1:0] s_wdata_o,
  output logic              s_read_o,
  output logic              s_write_o,
  input  logic [DATA_W-1:0] s_rdata_i,
  input  logic              s_wait_i
);
  logic m_req, m_wr, m_ack_sync;
  logic s_ack, s_req_sync;

  mm_cdc_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk_i(s_clk_i), .rst_ni(rst_ni), .d_i(m_req), .q_o(s_req_sync)
  );

  mm_cdc_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk_i(m_clk_i), .rst_ni(rst_ni), .d_i(s_ack), .q_o(m_ack_sync)
  );

  mm_cdc_mfsm mfsm_i (
    .clk_i(m_clk_i), .rst_ni(rst_ni),
    .read_i(m_read_i), .write_i(m_write_i), .ack_i(m_ack_sync),
    .wait_o(m_wait_o), .req_o(m_req), .wr_o(m_wr)
  );

  mm_cdc_sfsm #(.DATA_W(DATA_W)) sfsm_i (
    .clk_i(s_clk_i), .rst_ni(rst_ni),
    .req_i(s_req_sync), .wr_i(m_wr), .wait_i(s_wait_i), .rdata_i(s_rdata_i),
    .read_o(s_read_o), .write_o(s_write_o), .rdata_o(m_rdata_o), .ack_o(s_ack)
  );

  // payload held stable by the stalled master
  assign s_addr_o  = m_addr_i;
  assign s_be_o    = m_be_i;
  assign s_wdata_o = m_wdata_i;
endmodule

// File: rtl/mm_cdc_bridge_chk.sv
module mm_cdc_bridge_chk (
  input logic m_clk_i,
  input logic s_clk_i,
  input logic rst_ni,
  input logic m_read_i,
  input logic m_write_i,
  input logic m_wait_o,
  input logic s_read_o,
  input logic s_write_o,
  input logic s_wait_i,
  input logic m_req,
  input logic m_ack_sync,
  input logic s_ack,
  input logic s_req_sync
);
  AST_STALL_AT_START: assert property (@(posedge m_clk_i) disable iff (!rst_ni)
    ($rose(m_read_i) || $rose(m_write_i)) |-> m_wait_o); // R2
  AST_STROBE_EXCL: assert property (@(posedge s_clk_i) disable iff (!rst_ni)
    !(s_read_o && s_write_o)); // R3
  AST_STROBE_HOLD: assert property (@(posedge s_clk_i) disable iff (!rst_ni)
    ((s_read_o || s_write_o) && s_wait_i) |=> ($stable(s_read_o) && $stable(s_write_o))); // R5
  AST_REQ_HOLD: assert property (@(posedge m_clk_i) disable iff (!rst_ni)
    (m_req && !m_ack_sync) |=> m_req); // R6
  AST_ACK_HOLD: assert property (@(posedge s_clk_i) disable iff (!rst_ni)
    (s_ack && s_req_sync) |=> s_ack); // R6
  AST_REQ_START_REST: assert property (@(posedge m_clk_i) disable iff (!rst_ni)
    $rose(m_req) |-> !m_ack_sync); // R6
endmodule

bind mm_cdc_bridge mm_cdc_bridge_chk chk_i (.*);

// File: tb/mm_cdc_bridge_tb_top.sv
`timescale 1ns/1ps
module mm_cdc_bridge_tb_top;
  logic        m_clk = 1'b0, s_clk = 1'b0, rst_ni = 1'b0;
  logic [15:0] m_addr_i = '0;
  logic [3:0]  m_be_i = '0;
  logic [31:0] m_wdata_i = '0;
  logic        m_read_i = 1'b0, m_write_i = 1'b0;
  logic [31:0] m_rdata_o;
  logic        m_wait_o;
  logic [15:0] s_addr_o;
  logic [3:0]  s_be_o;
  logic [31:0] s_wdata_o;
  logic        s_read_o, s_write_o;
  logic [31:0] s_rdata_i = '0;
  logic        s_wait_i = 1'b1;

  int total = 0, bad = 0, mst_cnt = 0, slv_cnt = 0, slv_wr = 0, s_half = 2;
  bit done = 1'b0;
  logic [31:0] shadow [16];
  logic [31:0] smem [16];
  bit          cur_wr;
  logic [15:0] cur_addr;
  logic [31:0] cur_data;
  logic [3:0]  cur_be;

  mm_cdc_bridge dut_i (
    .m_clk_i(m_clk), .s_clk_i(s_clk), .rst_ni(rst_ni),
    .m_addr_i(m_addr_i), .m_be_i(m_be_i), .m_wdata_i(m_wdata_i),
    .m_read_i(m_read_i), .m_write_i(m_write_i),
    .m_rdata_o(m_rdata_o), .m_wait_o(m_wait_o),
    .s_addr_o(s_addr_o), .s_be_o(s_be_o), .s_wdata_o(s_wdata_o),
    .s_read_o(s_read_o), .s_write_o(s_write_o),
    .s_rdata_i(s_rdata_i), .s_wait_i(s_wait_i)
  );

  initial forever #4 m_clk = ~m_clk;
  initial forever #(s_half) s_clk = ~s_clk;

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // slave model: random wait states, decisions at negedge
  initial begin
    bit started = 1'b0;
    int cnt = 0;
    for (int i = 0; i < 16; i++) smem[i] = '0;
    forever begin
      @(negedge s_clk);
      if (s_read_o || s_write_o) begin
        if (!started) begin
          started = 1'b1;
          cnt = int'($urandom % 4);
        end
        if (cnt == 0) begin
          s_wait_i = 1'b0;
          slv_cnt++;
          chk(s_addr_o == cur_addr, "R3 addr", 32'(s_addr_o), 32'(cur_addr));
          chk(s_write_o == cur_wr, "R3 type", 32'(s_write_o), 32'(cur_wr));
          if (s_write_o) begin
            slv_wr++;
            chk(s_wdata_o == cur_data, "R3 wdata", s_wdata_o, cur_data);
            chk(s_be_o == cur_be, "R3 be", 32'(s_be_o), 32'(cur_be));
            smem[s_addr_o[3:0]] = merge(smem[s_addr_o[3:0]], s_wdata_o, s_be_o);
          end else begin
            s_rdata_i = smem[s_addr_o[3:0]];
          end
        end else begin
          s_wait_i = 1'b1;
          cnt--;
        end
      end else begin
        started = 1'b0;
        s_wait_i = 1'b1;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [15:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd);
    int n = 0;
    @(negedge m_clk);
    cur_wr = wr; cur_addr = a; cur_data = d; cur_be = be;
    m_addr_i = a; m_wdata_i = d; m_be_i = be;
    m_write_i = wr; m_read_i = !wr;
    #1;
    chk(m_wait_o == 1'b1, "R2 stall", 32'(m_wait_o), 32'd1);
    forever begin
      @(negedge m_clk);
      if (!m_wait_o) break;
      n++;
      if (n > 2000) begin
        chk(1'b0, "R6 hang", 32'(n), 32'd0);
        break;
      end
    end
    rd = m_rdata_o;
    mst_cnt++;
    chk(slv_cnt == mst_cnt, "R6 one in flight", 32'(slv_cnt), 32'(mst_cnt));
    @(posedge m_clk);
    #1;
    m_read_i = 1'b0; m_write_i = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] rd;
    xfer(1'b1, a, d, be, rd);
    shadow[a[3:0]] = merge(shadow[a[3:0]], d, be);
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] rd);
    xfer(1'b0, a, '0, '0, rd);
    chk(rd == shadow[a[3:0]], "R4 rdata", rd, shadow[a[3:0]]);
  endtask

  task automatic run_phase(input int half, input string tag);
    int base_s, base_w, wr_n;
    logic [31:0] rd;
    s_half = half;
    repeat (4) @(negedge m_clk);
    base_s = slv_cnt; base_w = slv_wr; wr_n = 0;
    for (int i = 0; i < 50; i++) begin
      if ($urandom % 2 == 0) begin
        do_write(16'($urandom), $urandom, 4'($urandom));
        wr_n++;
      end else begin
        do_read(16'($urandom), rd);
      end
    end
    chk(slv_cnt - base_s == 50, {"R7 ", tag, " completions"}, 32'(slv_cnt - base_s), 32'd50);
    chk(slv_wr - base_w == wr_n, {"R5 ", tag, " writes once"}, 32'(slv_wr - base_w), 32'(wr_n));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, held;
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge m_clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge m_clk);
    chk(m_wait_o == 1'b0, "R1 wait", 32'(m_wait_o), 32'd0);
    chk(s_read_o == 1'b0, "R1 read", 32'(s_read_o), 32'd0);
    chk(s_write_o == 1'b0, "R1 write", 32'(s_write_o), 32'd0);

    // directed: full write, partial write, back-to-back read of same word
    do_write(16'h0003, 32'hA5A5_1234, 4'hF);
    do_write(16'h0013, 32'hFFEE_DDCC, 4'b0101);
    do_read(16'h0003, rd);
    chk(rd == 32'hA5EE_12CC, "R4 partial be", rd, 32'hA5EE_12CC);
    held = rd;
    repeat (6) @(negedge m_clk);
    chk(m_rdata_o == held, "R8 idle hold", m_rdata_o, held);
    do_write(16'h0005, 32'h0BAD_F00D, 4'hF);
    repeat (3) @(negedge m_clk);
    chk(m_rdata_o == held, "R8 write hold", m_rdata_o, held);
    do_read(16'h0005, rd);
    chk(rd == 32'h0BAD_F00D, "R6 back-to-back", rd, 32'h0BAD_F00D);

    run_phase(2, "fast slave");
    run_phase(13, "slow slave");
    run_phase(5, "near ratio");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule